// File: doc/BRIEF.md
# Configurable External Interrupt Pin Detector

This block watches a single external interrupt pin and turns its activity into a status flag and an interrupt request. A small control register sets it up. One bit enables the pin as an interrupt input. One bit picks the active polarity. One bit chooses between detecting edges only and detecting edges plus a held level. One bit lets the flag drive the interrupt request. A write-one bit acknowledges and clears the flag. Software can leave the request disabled and poll the flag instead. The same register also returns the flag and the synchronized pin level.

The pin passes through a synchronizer chain of `SYNC_STAGES` flops, two by default, before any detection. Edges are found by comparing the newest synchronized sample with the one before it. While the device is in stop mode with its clock halted, a separate combinational path drives a wake output straight from the raw pin. This path does not depend on any sampled state.

Top module: `ext_pin_irq`

## Requirements
- R1: While the enable bit (write bit 0) is 0, the flag is never set, `irqReq` stays 0, `wakeOut` stays 0 and the level read bit reads 0.
- R2: The polarity bit (write bit 1) selects the active sense: 0 means a falling edge or low level, 1 means a rising edge or high level. A transition to the inactive level never sets the flag.
- R3: With the mode bit (write bit 2) at 0, only a transition into the active level sets the flag. After an acknowledge, the flag stays clear while the pin is held active.
- R4: With the mode bit at 1, the flag is set again on the edge right after an acknowledge, for as long as the synchronized pin stays at the active level.
- R5: Writing 1 to the acknowledge bit (write bit 4) clears the flag (read bit 5) at the next clock edge. An event that arrives later sets it again.
- R6: `irqReq` is high exactly when the flag is set, the interrupt-enable bit (write bit 3) is 1 and the pin is enabled. With interrupt-enable at 0 the flag can still be polled.
- R7: If an acknowledge and a new event fall in the same clock cycle, the flag stays set.
- R8: `wakeOut` is high, with no clock edge needed, whenever `stopMode` is 1, the pin is enabled and the raw pin is at the active level. Otherwise it is 0.
- R9: Read bit 6 returns the synchronized pin level `SYNC_STAGES` clock edges after the pin changes, and only while the pin is enabled.
- R10: After reset, the read value is 0 and both `irqReq` and `wakeOut` are 0.
- R11: Changing the polarity bit while the synchronized pin level is steady does not create an edge event.
- R12: With the default two-stage synchronizer, the flag is visible three clock edges after the pin changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrite | input | 1 | Write strobe for the control register |
| cfgWdata | input | 5 | Write data: bit0 enable, bit1 polarity, bit2 mode, bit3 interrupt enable, bit4 acknowledge |
| cfgRdata | output | 7 | Read data: bits 0–3 configuration, bit4 zero, bit5 flag, bit6 synchronized level |
| pinIn | input | 1 | External interrupt pin, asynchronous |
| stopMode | input | 1 | High while the device is in stop mode |
| irqReq | output | 1 | Interrupt request |
| wakeOut | output | 1 | Asynchronous wake request |

## Verification
The bench builds the block with the default two-stage synchronizer. With that setting, every latency it checks is a small fixed number of edges: two for the level readback and three for the flag. At this size the bench can sweep all sixteen combinations of enable, polarity, mode and interrupt enable. For each combination it works out the expected flag, request, wake and readback from the bits themselves. Directed cases then place an acknowledge in the exact cycle an edge event is pending, and flip the polarity under a steady pin.

// File: rtl/ext_pin_irq_pkg.sv
package ext_pin_irq_pkg;
  localparam int WR_W   = 5;
  localparam int RD_W   = 7;
  localparam int B_EN   = 0;
  localparam int B_POL  = 1;
  localparam int B_LVL  = 2;
  localparam int B_IE   = 3;
  localparam int B_ACK  = 4;
  localparam int B_FLAG = 5;
  localparam int B_PIN  = 6;

  typedef struct packed {
    logic pinEn;
    logic polHigh;
    logic levelMode;
    logic irqEn;
    logic ackFlag;
  } ctlStrobes_t;
endpackage

// File: rtl/ext_pin_irq_ctrl.sv
module ext_pin_irq_ctrl
  import ext_pin_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWrite,
  input  logic [WR_W-1:0] cfgWdata,
  output ctlStrobes_t     strb
);
  logic pinEnQ, polQ, lvlQ, ieQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinEnQ <= 1'b0;
      polQ   <= 1'b0;
      lvlQ   <= 1'b0;
      ieQ    <= 1'b0;
    end else if (cfgWrite) begin
      pinEnQ <= cfgWdata[B_EN];
      polQ   <= cfgWdata[B_POL];
      lvlQ   <= cfgWdata[B_LVL];
      ieQ    <= cfgWdata[B_IE];
    end
  end

  always_comb begin
    strb.pinEn     = pinEnQ;
    strb.polHigh   = polQ;
    strb.levelMode = lvlQ;
    strb.irqEn     = ieQ;
    strb.ackFlag   = cfgWrite & cfgWdata[B_ACK];
  end
endmodule

// File: rtl/ext_pin_irq_dp.sv
module ext_pin_irq_dp
  import ext_pin_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinIn,
  input  logic        stopMode,
  input  ctlStrobes_t strb,
  output logic        flagQ,
  output logic        syncLevel,
  output logic        irqReq,
  output logic        wakeOut
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic prevLevel;
  logic curActive, prevActive, edgeHit, eventHit;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= pinIn;
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[g] <= 1'b0;
          else       syncChain[g] <= syncChain[g-1];
      end
    end
  endgenerate

  assign syncLevel = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= syncLevel;

  // Both samples are judged under the current polarity, so a polarity flip is not an edge.
  assign curActive  = syncLevel ~^ strb.polHigh;
  assign prevActive = prevLevel ~^ strb.polHigh;
  assign edgeHit    = curActive & ~prevActive;
  assign eventHit   = strb.pinEn & (edgeHit | (strb.levelMode & curActive));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) flagQ <= 1'b0;
    else       flagQ <= (flagQ & ~strb.ackFlag) | eventHit;

  assign irqReq  = flagQ & strb.irqEn & strb.pinEn;
  assign wakeOut = stopMode & strb.pinEn & (pinIn ~^ strb.polHigh);

  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.pinEn && !flagQ) |=> !flagQ); // R1
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackFlag && !eventHit) |=> !flagQ); // R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    eventHit |=> flagQ); // R7
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pinEn && strb.levelMode && curActive) |=> flagQ); // R4
endmodule

// File: rtl/ext_pin_irq.sv
module ext_pin_irq
  import ext_pin_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWrite,
  input  logic [WR_W-1:0] cfgWdata,
  output logic [RD_W-1:0] cfgRdata,
  input  logic            pinIn,
  input  logic            stopMode,
  output logic            irqReq,
  output logic            wakeOut
);
  ctlStrobes_t strb;
  logic flagQ, syncLevel;

  ext_pin_irq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgWdata(cfgWdata), .strb(strb)
  );

  ext_pin_irq_dp #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .stopMode(stopMode), .strb(strb),
    .flagQ(flagQ), .syncLevel(syncLevel), .irqReq(irqReq), .wakeOut(wakeOut)
  );

  always_comb begin
    cfgRdata         = '0;
    cfgRdata[B_EN]   = strb.pinEn;
    cfgRdata[B_POL]  = strb.polHigh;
    cfgRdata[B_LVL]  = strb.levelMode;
    cfgRdata[B_IE]   = strb.irqEn;
    cfgRdata[B_FLAG] = flagQ;
    cfgRdata[B_PIN]  = strb.pinEn & syncLevel;
  end
endmodule

// File: tb/ext_pin_irq_test.sv
`timescale 1ns/1ps
module ext_pin_irq_test;
  localparam int LAT = 2;
  logic clk = 1'b0, rstN = 1'b0, cfgWrite = 1'b0, pinIn = 1'b0, stopMode = 1'b0;
  logic [4:0] cfgWdata = '0;
  logic [6:0] cfgRdata;
  logic irqReq, wakeOut;
  int checks = 0, failures = 0;
  bit finished = 0;

  ext_pin_irq uut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .pinIn(pinIn), .stopMode(stopMode),
    .irqReq(irqReq), .wakeOut(wakeOut)
  );

  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] d);
    cfgWrite = 1'b1; cfgWdata = d;
    tick(1);
    cfgWrite = 1'b0;
  endtask

  function automatic logic [4:0] cfg(input bit ack, ie, md, pol, en);
    return {ack, ie, md, pol, en};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R10 rdata", cfgRdata, 0);
    chk("R10 irq", irqReq, 0);
    chk("R10 wake", wakeOut, 0);
    rstN = 1'b1;
    tick(2);

    for (int c = 0; c < 16; c++) begin
      bit en, pol, md, ie;
      en = c[0]; pol = c[1]; md = c[2]; ie = c[3];
      wr(cfg(1, ie, md, pol, 0));
      pinIn = ~pol;
      tick(LAT + 2);
      wr(cfg(1, ie, md, pol, en));
      tick(2);
      chk("R2 inactive no flag", cfgRdata[5], 0);
      chk("R1 level bit inactive", cfgRdata[6], en & ~pol);
      pinIn = pol;
      tick(LAT);
      chk("R9 level readback", cfgRdata[6], en & pol);
      tick(1);
      chk("R12 R2 R1 flag set", cfgRdata[5], en);
      chk("R6 irq gating", irqReq, en & ie);
      stopMode = 1'b1; #1;
      chk("R8 wake active", wakeOut, en);
      stopMode = 1'b0; #1;
      chk("R8 wake needs stop", wakeOut, 0);
      wr(cfg(1, ie, md, pol, en));
      chk("R3 R4 after ack", cfgRdata[5], en & md);
      tick(2);
      chk("R3 R4 held", cfgRdata[5], en & md);
      pinIn = ~pol;
      stopMode = 1'b1; #1;
      chk("R8 wake inactive", wakeOut, 0);
      stopMode = 1'b0;
      tick(LAT + 1);
      wr(cfg(1, ie, md, pol, en));
      chk("R5 ack clears", cfgRdata[5], 0);
      pinIn = pol;
      tick(LAT + 1);
      chk("R5 re-set after ack", cfgRdata[5], en);
      chk("R6 irq after re-set", irqReq, en & ie);
      pinIn = ~pol;
      tick(LAT + 1);
    end

    // R7: acknowledge lands in the cycle an edge event is pending
    wr(cfg(1, 0, 0, 1, 1));
    pinIn = 1'b0; tick(LAT + 2);
    wr(cfg(1, 0, 0, 1, 1));
    chk("R7 pre clear", cfgRdata[5], 0);
    pinIn = 1'b1;
    tick(LAT);
    wr(cfg(1, 0, 0, 1, 1));
    chk("R7 ack with event", cfgRdata[5], 1);
    wr(cfg(1, 0, 0, 1, 1));
    chk("R3 edge mode stays clear", cfgRdata[5], 0);

    // R11: polarity flip under a steady pin
    wr(cfg(1, 0, 0, 0, 1));
    tick(LAT + 2);
    wr(cfg(1, 0, 0, 0, 1));
    chk("R11 pre", cfgRdata[5], 0);
    wr(cfg(0, 0, 0, 1, 1));
    tick(LAT + 1);
    chk("R11 no spurious edge", cfgRdata[5], 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule